// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block decides which of four DMA channels is serviced next. Each channel has a hardware request line and a software request bit. The two are ORed, and any channel whose mask bit is set is then removed. While no grant is outstanding, the arbiter samples the eligible requests on every clock. When at least one is present, it registers a one-hot grant and raises a valid flag toward the transfer sequencer.

A grant, once issued, stays fixed until the sequencer pulses the service-done input. Requests that change while the grant is held are not looked at.

Two priority schemes are available, chosen by a mode input:

- **Fixed mode:** the lowest-numbered eligible channel wins.
- **Rotating mode:** a pointer names the channel with the highest priority. On service-done, the pointer moves to the channel after the one just serviced, so that channel becomes the lowest priority. The pointer does not move in fixed mode. Reset puts it on channel 0.

Top module: `dma_prio_arb`

## Requirements
- R1: After reset, `grant` is 0, `grant_vld` is 0, and the rotation pointer places channel 0 at the highest priority.
- R2: In fixed mode (`rotate_en`=0), the eligible channel with the lowest index is granted; bit i of `grant` stands for channel i.
- R3: While `grant_vld` is 1 and `svc_done` is 0, `grant` keeps its value whatever the request, mask or mode inputs do.
- R4: `svc_done`=1 while `grant_vld`=1 clears `grant` and `grant_vld` on the next clock. Arbitration resumes on the clock after that.
- R5: In rotating mode, service-done on channel k makes the order for the next arbitration k+1, k+2, k+3, k (mod 4). In fixed mode, service-done leaves the pointer unchanged.
- R6: A channel whose `chan_mask` bit is 1 is never granted. With every requester masked, the arbiter stays idle.
- R7: `sw_req[i]` requests channel i exactly as `hw_req[i]` does.
- R8: Requests are sampled only on clocks where `grant_vld` is 0. A request that rises and falls while a grant is held is never recognised.
- R9: In rotating mode with all four channels requesting continuously, each channel is granted once in every four consecutive services.
- R10: When `grant_vld` is 1, exactly one bit of `grant` is set. When `grant_vld` is 0, `grant` is zero. A grant appears only on a channel that was eligible on the sampling clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | NCH | Hardware request per channel |
| sw_req | input | NCH | Software request per channel |
| chan_mask | input | NCH | 1 masks the channel from arbitration |
| rotate_en | input | 1 | 1 selects rotating priority, 0 selects fixed |
| svc_done | input | 1 | Service of the granted channel has ended |
| grant | output | NCH | One-hot granted channel |
| grant_vld | output | 1 | A grant is outstanding |

## Verification
A corrupt rotation pointer does not show until the next arbitration in rotating mode. It then grants the wrong channel out of a full request set, one clock after the idle sampling edge. The bench therefore serves long runs with every channel requesting. A lost busy state would let the grant change mid-service within one clock, so each held grant is observed over several clocks while competing requests arrive. A wrong mask or OR path shows as a wrong channel on the very first grant after the stimulus.

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hw_req,
  input  logic [NCH-1:0] sw_req,
  input  logic [NCH-1:0] chan_mask,
  input  logic           rotate_en,
  input  logic           svc_done,
  output logic [NCH-1:0] grant,
  output logic           grant_vld
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] eff, pick, grant_q, eff_low;
  logic [IW-1:0]  hi_ptr, gidx, nxt_ptr;
  logic           found;

  assign eff       = (hw_req | sw_req) & ~chan_mask;
  assign grant     = grant_q;
  assign grant_vld = |grant_q;
  assign eff_low   = eff & (~eff + NCH'(1));

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int k = 0; k < NCH; k++) begin
      int j;
      j = rotate_en ? (int'(hi_ptr) + k) % NCH : k;
      if (!found && eff[j]) begin
        pick[j] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  always_comb begin
    gidx = '0;
    for (int k = 0; k < NCH; k++)
      if (grant_q[k]) gidx = IW'(k);
  end

  assign nxt_ptr = IW'((int'(gidx) + 1) % NCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= '0;
      hi_ptr  <= '0;
    end else if (!grant_vld) begin
      if (found) grant_q <= pick;
    end else if (svc_done) begin
      grant_q <= '0;
      if (rotate_en) hi_ptr <= nxt_ptr;
    end
  end

  // R3
  a_r3_hold_grant: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld && !svc_done |=> grant_vld && $stable(grant));
  // R4
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld && svc_done |=> !grant_vld);
  // R10
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> $countones(grant) == 1);
  // R6 R10
  a_r6_eligible_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_vld) |-> (grant & $past(eff)) != '0);
  // R6
  a_r6_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_vld && eff == '0 |=> !grant_vld);
  // R2
  a_r2_fixed_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_vld) && !$past(rotate_en) |-> grant == $past(eff_low));
endmodule

// File: tb/dma_prio_arb_tb.sv
module dma_prio_arb_tb_top;
  localparam int NCH = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] hw_req = '0, sw_req = '0, chan_mask = '0;
  logic rotate_en = 1'b0, svc_done = 1'b0;
  logic [NCH-1:0] grant;
  logic grant_vld;

  int checks = 0, fails = 0;
  bit done_flag = 0;
  logic prev_vld = 1'b0;
  logic [NCH-1:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  dma_prio_arb #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_req(sw_req),
    .chan_mask(chan_mask), .rotate_en(rotate_en), .svc_done(svc_done),
    .grant(grant), .grant_vld(grant_vld));

  task automatic chk(bit ok, string tag, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // monitor: pops expected grants when a new grant appears
  always @(negedge clk) begin
    if (rst_n && grant_vld && !prev_vld) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected grant", grant, '0);
      else begin
        logic [NCH-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(grant == e, t, grant, e);
      end
    end
    prev_vld <= rst_n ? grant_vld : 1'b0;
  end

  task automatic serve(logic [NCH-1:0] exp, string tag, int hold);
    int n;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    n = 0;
    @(negedge clk);
    while (!grant_vld && n < 20) begin
      @(negedge clk);
      n++;
    end
    if (!grant_vld) chk(1'b0, {tag, " no grant"}, grant, exp);
    for (int i = 0; i < hold; i++) begin
      hw_req = hw_req ^ 4'b1111;
      @(negedge clk);
      chk(grant == exp, "R3 grant held", grant, exp);
    end
    svc_done = 1'b1;
    @(negedge clk);
    svc_done = 1'b0;
    chk(!grant_vld && grant == '0, "R4 cleared after done", grant, '0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #20000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%b expected=%b", grant, 4'b0);
    finish_run();
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(grant == '0 && !grant_vld, "R1 reset state", grant, '0);
    chk(grant == '0, "R10 zero grant when idle", grant, '0);

    // fixed priority
    hw_req = 4'b1010;
    serve(4'b0010, "R2 fixed lowest of 1010", 0);
    hw_req = 4'b1111;
    serve(4'b0001, "R2 fixed ch0 of 1111", 3);
    hw_req = 4'b1111;
    serve(4'b0001, "R5 fixed no rotation", 0);

    // masking
    chan_mask = 4'b0001;
    hw_req = 4'b1111;
    serve(4'b0010, "R6 masked ch0 skipped", 0);
    chan_mask = 4'b1111;
    repeat (5) @(negedge clk);
    chk(!grant_vld, "R6 all masked idle", grant, '0);
    chan_mask = 4'b0000;
    hw_req = 4'b0000;

    // software request
    sw_req = 4'b0100;
    serve(4'b0100, "R7 software request", 0);
    sw_req = 4'b0000;

    // request pulse while busy is lost
    hw_req = 4'b0001;
    exp_q.push_back(4'b0001);
    tag_q.push_back("R8 first grant");
    repeat (2) @(negedge clk);
    hw_req = 4'b1000;
    @(negedge clk);
    hw_req = 4'b0000;
    @(negedge clk);
    svc_done = 1'b1;
    @(negedge clk);
    svc_done = 1'b0;
    repeat (4) @(negedge clk);
    chk(!grant_vld, "R8 pulse during service ignored", grant, '0);

    // rotating: pointer still at ch0 after fixed services
    rotate_en = 1'b1;
    hw_req = 4'b1111;
    serve(4'b0001, "R5 pointer kept from fixed", 0);
    hw_req = 4'b1111;
    serve(4'b0010, "R9 rotate ch1", 1);
    hw_req = 4'b1111;
    serve(4'b0100, "R9 rotate ch2", 0);
    hw_req = 4'b1111;
    serve(4'b1000, "R9 rotate ch3", 0);
    hw_req = 4'b1111;
    serve(4'b0001, "R9 rotate wraps ch0", 0);
    hw_req = 4'b1001;
    serve(4'b1000, "R5 after ch0 order 1,2,3,0", 0);
    hw_req = 4'b1001;
    serve(4'b0001, "R5 after ch3 ch0 first", 0);
    chan_mask = 4'b0010;
    hw_req = 4'b1111;
    serve(4'b0100, "R6 rotate skips masked ch1", 0);
    chan_mask = 4'b0000;

    // reset puts pointer back on ch0
    do_reset();
    hw_req = 4'b1111;
    serve(4'b0001, "R1 pointer reset to ch0", 0);
    hw_req = 4'b0000;
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all expected grants seen", '0, '0);
    finish_run();
  end
endmodule